// File: doc/BRIEF.md
# Timebase Synchronization Sequencer

This block is the per-core controller that steps a local timebase through its bring-up sequence against an external time-of-day unit. Firmware drives it by writing a 64-bit control/status register and polling it with reads. Each read advances the machine one step. A pair of countdown delays, counted in reads rather than clock cycles, paces the transitions. The time-of-day unit takes part through two inputs: a sync pulse and a strobe that reports a time value has been delivered. The block answers with a request that asks for that value.

The readable register is laid out as follows:
- bits [3:0]: the state code.
- bits [7:4]: the previous state code.
- bit 8: the timebase-valid flag.
- bit 9: the sync-occurred flag.
- bit 10: the firmware-control-error flag.
- bit 16: the load-mode command.
- bit 17: the move-to-timebase command.
- bit 18: the clear-errors command.
- bit 19: the mode-enable bit.
- All other bits are free storage.

The timebase counter itself is not part of the block. Only the decoded write indications for its upper and lower halves enter, because a lower-half write breaks synchronization.

Priority within one cycle is: register write first, then timebase-half write, then read. A read that shares a cycle with either kind of write does not step the machine.

Top module: `tbsync_top`

## Requirements
- R1: After reset, the register reads 0x0000_0000_0008_0000 (only the mode-enable bit 19 set) and `tod_req_o` is low.
- R2: The state field only ever holds codes 0 reset, 1 send-mode, 2 not-set, 6 sync-wait, 7 get-time, 8 running or 9 error, and bit 8 is 1 exactly when the state is 8.
- R3: On every state change, bits [7:4] take the previous value of bits [3:0]. The only exception is the load-mode pass, which goes through code 1 on its way to code 2 and so leaves 1 in bits [7:4].
- R4: A write with bit 16 set loads a delay of 3 reads. The fourth read clears bit 16 and moves the state to 2, with 1 in the last-state field. If that read finds the state at 7, the machine goes to 9 and sets bit 10 instead.
- R5: A write with bit 17 set moves state 2 to 6, raises `tod_req_o` and loads the 3-read delay. The same write from any other state moves to 9, sets bit 10 and drops `tod_req_o`.
- R6: In state 6, the fourth read moves to 7 and reloads the delay. In state 7, once the delay has elapsed, a read moves to 8 only when a delivery has been seen, either latched earlier or on `tod_done_i` in that same cycle. That read clears bit 17, drops `tod_req_o` and forgets the delivery.
- R7: A write with both bit 16 and bit 17 set forces state 9 and sets bit 10.
- R8: A write with bit 18 set (and not both command bits) moves to state 0. It clears bits 16, 17, 18 and 10, drops `tod_req_o` and forgets any delivery.
- R9: In state 9, any write without bit 18 only sets bit 10: state and command bits stay unchanged, and reads do not step the machine.
- R10: A lower-half timebase write in state 8 moves to 9. An upper-half write in state 8, and any timebase write in state 2, leave the state unchanged.
- R11: Every register write clears bit 9. Outside state 9, bit 9 returns on the second read after the write. `tod_sync_i` sets bit 9 too, but a register write in the same cycle wins.
- R12: Bit 19 always reads as 1. Bits 11 to 15 and 20 to 63 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Register write strobe |
| wr_data_i | input | 64 | Register write data |
| rd_strobe_i | input | 1 | Register read strobe; steps the machine |
| tb_wr_upper_i | input | 1 | A write to the upper timebase half happened |
| tb_wr_lower_i | input | 1 | A write to the lower timebase half happened |
| tod_sync_i | input | 1 | Sync pulse from the time-of-day unit |
| tod_done_i | input | 1 | Time value delivered to the timebase |
| tod_req_o | output | 1 | Ready for a time value |
| rd_data_o | output | 64 | Register contents, reflecting any step taken at the last edge |

## Verification
Two pairs of events can meet in one cycle. In the first, the delivery strobe arrives in the same cycle as the read that ends the get-time wait. The bench provokes this by pulsing `tod_done_i` together with that read, and the machine must reach running at once rather than one read later. In the second, a sync pulse coincides with a register write. Here the sync-occurred bit must read 0 afterwards. A behavioural model in the bench judges every cycle, and named checks pin the state, last-state and flag fields at each of these points.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;

  localparam int unsigned REG_W = 64;

  localparam logic [3:0] ST_RESET  = 4'd0;
  localparam logic [3:0] ST_SEND   = 4'd1;
  localparam logic [3:0] ST_NOTSET = 4'd2;
  localparam logic [3:0] ST_WAIT   = 4'd6;
  localparam logic [3:0] ST_GET    = 4'd7;
  localparam logic [3:0] ST_RUN    = 4'd8;
  localparam logic [3:0] ST_ERR    = 4'd9;

  localparam int unsigned B_STATE = 0;
  localparam int unsigned B_LAST  = 4;
  localparam int unsigned B_VALID = 8;
  localparam int unsigned B_SYNC  = 9;
  localparam int unsigned B_ERR   = 10;
  localparam int unsigned B_LOAD  = 16;
  localparam int unsigned B_MOVE  = 17;
  localparam int unsigned B_CLR   = 18;
  localparam int unsigned B_MODE  = 19;

  localparam logic [REG_W-1:0] FIELD_MASK = 64'h0000_0000_000F_07FF;
  localparam logic [REG_W-1:0] FREE_MASK  = ~FIELD_MASK;

  typedef struct packed {
    logic [REG_W-1:0] free;
    logic             clr;
    logic             move;
    logic             load;
    logic             err;
    logic             sync;
    logic             valid;
    logic [3:0]       last;
    logic [3:0]       state;
  } ctl_t;

  // Shift the current code into the history field, then install the new code.
  function automatic ctl_t go_state(ctl_t c, logic [3:0] nxt);
    ctl_t r;
    r       = c;
    r.last  = c.state;
    r.state = nxt;
    r.valid = (nxt == ST_RUN);
    return r;
  endfunction

  // Assemble the readable image; the mode bit always reads as one.
  function automatic logic [REG_W-1:0] pack_reg(ctl_t c);
    logic [REG_W-1:0] r;
    r               = c.free & FREE_MASK;
    r[B_STATE+:4]   = c.state;
    r[B_LAST+:4]    = c.last;
    r[B_VALID]      = c.valid;
    r[B_SYNC]       = c.sync;
    r[B_ERR]        = c.err;
    r[B_LOAD]       = c.load;
    r[B_MOVE]       = c.move;
    r[B_CLR]        = c.clr;
    r[B_MODE]       = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/tbsync_delay.sv
module tbsync_delay #(
  parameter int unsigned W        = 2,
  parameter int unsigned LOAD_VAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= W'(LOAD_VAL);
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tbsync_core.sv
module tbsync_core
  import tbsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_strobe_i,
  input  logic             tb_wr_upper_i,
  input  logic             tb_wr_lower_i,
  input  logic             tod_sync_i,
  input  logic             tod_done_i,
  input  logic             sdly_zero_i,
  input  logic             pdly_zero_i,
  output logic             sdly_load_o,
  output logic             sdly_dec_o,
  output logic             pdly_load_o,
  output logic             pdly_dec_o,
  output logic             tod_req_o,
  output logic [REG_W-1:0] rd_data_o
);

  ctl_t cur_q, nxt;
  logic ready_q, ready_d;
  logic deliv_q, deliv_d;

  // Named internal events.
  logic ev_tb_wr;
  logic ev_step;
  logic ev_conflict;
  logic ev_clear;
  logic ev_err_wr;
  logic deliv_seen;

  assign ev_tb_wr    = !wr_valid_i && (tb_wr_upper_i || tb_wr_lower_i);
  assign ev_step     = !wr_valid_i && !ev_tb_wr && rd_strobe_i && (cur_q.state != ST_ERR);
  assign ev_conflict = wr_valid_i && wr_data_i[B_LOAD] && wr_data_i[B_MOVE];
  assign ev_clear    = wr_valid_i && !ev_conflict && wr_data_i[B_CLR];
  assign ev_err_wr   = wr_valid_i && !ev_conflict && !ev_clear && (cur_q.state == ST_ERR);
  assign deliv_seen  = deliv_q || tod_done_i;

  always_comb begin
    ctl_t tmp;
    nxt         = cur_q;
    ready_d     = ready_q;
    deliv_d     = deliv_seen;
    sdly_load_o = 1'b0;
    sdly_dec_o  = 1'b0;
    pdly_load_o = 1'b0;
    pdly_dec_o  = 1'b0;

    tmp         = cur_q;
    tmp.free    = wr_data_i & FREE_MASK;
    tmp.load    = wr_data_i[B_LOAD];
    tmp.move    = wr_data_i[B_MOVE];
    tmp.clr     = wr_data_i[B_CLR];
    tmp.sync    = 1'b0;
    if (wr_data_i[B_ERR]) tmp.err = 1'b0;

    if (wr_valid_i) begin
      pdly_load_o = 1'b1;
      if (ev_conflict) begin
        tmp     = go_state(tmp, ST_ERR);
        tmp.err = 1'b1;
        ready_d = 1'b0;
        nxt     = tmp;
      end else if (ev_clear) begin
        tmp      = go_state(tmp, ST_RESET);
        tmp.clr  = 1'b0;
        tmp.load = 1'b0;
        tmp.move = 1'b0;
        tmp.err  = 1'b0;
        ready_d  = 1'b0;
        deliv_d  = 1'b0;
        nxt      = tmp;
      end else if (ev_err_wr) begin
        nxt.err  = 1'b1;
        nxt.sync = 1'b0;
      end else begin
        if (tmp.load) begin
          sdly_load_o = 1'b1;
        end else if (tmp.move) begin
          if (cur_q.state == ST_NOTSET) begin
            tmp         = go_state(tmp, ST_WAIT);
            ready_d     = 1'b1;
            sdly_load_o = 1'b1;
          end else begin
            tmp     = go_state(tmp, ST_ERR);
            tmp.err = 1'b1;
            ready_d = 1'b0;
          end
        end
        nxt = tmp;
      end
    end else if (ev_tb_wr) begin
      if (tb_wr_lower_i && (cur_q.state == ST_RUN)) begin
        nxt = go_state(cur_q, ST_ERR);
      end
    end else if (ev_step) begin
      if (pdly_zero_i) nxt.sync = 1'b1;
      else             pdly_dec_o = 1'b1;

      if (!sdly_zero_i) begin
        sdly_dec_o = 1'b1;
      end else if (cur_q.load) begin
        nxt.load = 1'b0;
        if (cur_q.state == ST_GET) begin
          nxt     = go_state(nxt, ST_ERR);
          nxt.err = 1'b1;
        end else begin
          nxt = go_state(nxt, ST_SEND);
          nxt = go_state(nxt, ST_NOTSET);
        end
      end else if (cur_q.move) begin
        if (cur_q.state == ST_WAIT) begin
          nxt         = go_state(nxt, ST_GET);
          sdly_load_o = 1'b1;
        end else if (cur_q.state == ST_GET) begin
          if (deliv_seen) begin
            nxt      = go_state(nxt, ST_RUN);
            nxt.move = 1'b0;
            ready_d  = 1'b0;
            deliv_d  = 1'b0;
          end
        end else begin
          nxt     = go_state(nxt, ST_ERR);
          nxt.err = 1'b1;
          ready_d = 1'b0;
        end
      end
    end

    if (tod_sync_i && !wr_valid_i) nxt.sync = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q   <= '0;
      ready_q <= 1'b0;
      deliv_q <= 1'b0;
    end else begin
      cur_q   <= nxt;
      ready_q <= ready_d;
      deliv_q <= deliv_d;
    end
  end

  assign tod_req_o = ready_q;
  assign rd_data_o = pack_reg(cur_q);

endmodule

// File: rtl/tbsync_top.sv
module tbsync_top
  import tbsync_pkg::*;
#(
  parameter int unsigned STATE_DELAY = 3,
  parameter int unsigned PULSE_DELAY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid_i,
  input  logic [63:0] wr_data_i,
  input  logic        rd_strobe_i,
  input  logic        tb_wr_upper_i,
  input  logic        tb_wr_lower_i,
  input  logic        tod_sync_i,
  input  logic        tod_done_i,
  output logic        tod_req_o,
  output logic [63:0] rd_data_o
);

  localparam int unsigned SD_W = (STATE_DELAY < 2) ? 1 : $clog2(STATE_DELAY + 1);
  localparam int unsigned PD_W = (PULSE_DELAY < 2) ? 1 : $clog2(PULSE_DELAY + 1);

  logic sdly_zero, sdly_load, sdly_dec;
  logic pdly_zero, pdly_load, pdly_dec;

  tbsync_delay #(.W(SD_W), .LOAD_VAL(STATE_DELAY)) u_state_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (sdly_load),
    .dec_i  (sdly_dec),
    .zero_o (sdly_zero)
  );

  tbsync_delay #(.W(PD_W), .LOAD_VAL(PULSE_DELAY)) u_pulse_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (pdly_load),
    .dec_i  (pdly_dec),
    .zero_o (pdly_zero)
  );

  tbsync_core u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid_i    (wr_valid_i),
    .wr_data_i     (wr_data_i),
    .rd_strobe_i   (rd_strobe_i),
    .tb_wr_upper_i (tb_wr_upper_i),
    .tb_wr_lower_i (tb_wr_lower_i),
    .tod_sync_i    (tod_sync_i),
    .tod_done_i    (tod_done_i),
    .sdly_zero_i   (sdly_zero),
    .pdly_zero_i   (pdly_zero),
    .sdly_load_o   (sdly_load),
    .sdly_dec_o    (sdly_dec),
    .pdly_load_o   (pdly_load),
    .pdly_dec_o    (pdly_dec),
    .tod_req_o     (tod_req_o),
    .rd_data_o     (rd_data_o)
  );

endmodule

// File: rtl/tbsync_checker.sv
module tbsync_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid_i,
  input logic [63:0] wr_data_i,
  input logic        tb_wr_lower_i,
  input logic        tod_req_o,
  input logic [63:0] rd_data_o
);

  logic [3:0] st;
  logic [3:0] lst;
  assign st  = rd_data_o[3:0];
  assign lst = rd_data_o[7:4];

  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd8, 4'd9});

  assert_valid_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[8] == (st == 4'd8));

  assert_last_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> ((lst == $past(st)) || (st == 4'd2 && lst == 4'd1)));

  assert_run_noreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd8 && $past(st) != 4'd8) |-> !tod_req_o);

  assert_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_data_i[16] && wr_data_i[17]) |=> (st == 4'd9 && rd_data_o[10]));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_data_i[18] && !(wr_data_i[16] && wr_data_i[17]))
      |=> (st == 4'd0 && !rd_data_o[10] && !tod_req_o));

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd9 && !wr_valid_i) |=> (st == 4'd9));

  assert_tbl_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wr_lower_i && !wr_valid_i && st == 4'd8) |=> (st == 4'd9));

  assert_sync_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_i |=> !rd_data_o[9]);

endmodule

bind tbsync_top tbsync_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid_i    (wr_valid_i),
  .wr_data_i     (wr_data_i),
  .tb_wr_lower_i (tb_wr_lower_i),
  .tod_req_o     (tod_req_o),
  .rd_data_o     (rd_data_o)
);

// File: tb/test_tbsync_top.sv
`timescale 1ns/1ps
module test_tbsync_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_strobe = 1'b0;
  logic        tb_up = 1'b0;
  logic        tb_lo = 1'b0;
  logic        sync_p = 1'b0;
  logic        done_p = 1'b0;
  logic        req;
  logic [63:0] rd_data;

  always #2.5 clk = ~clk;

  tbsync_top i_tbsync_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid_i    (wr_valid),
    .wr_data_i     (wr_data),
    .rd_strobe_i   (rd_strobe),
    .tb_wr_upper_i (tb_up),
    .tb_wr_lower_i (tb_lo),
    .tod_sync_i    (sync_p),
    .tod_done_i    (done_p),
    .tod_req_o     (req),
    .rd_data_o     (rd_data)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // Behavioural reference model.
  localparam logic [63:0] FREE = ~64'h0000_0000_000F_07FF;
  logic [63:0] m_free;
  int m_st, m_last, m_sd, m_pd;
  bit m_valid, m_sync, m_err, m_ld, m_mv, m_cl, m_req, m_dv;

  task automatic m_reset();
    m_free = '0; m_st = 0; m_last = 0; m_sd = 0; m_pd = 0;
    m_valid = 0; m_sync = 0; m_err = 0; m_ld = 0; m_mv = 0; m_cl = 0;
    m_req = 0; m_dv = 0;
  endtask

  task automatic m_go(int s);
    m_last = m_st;
    m_st = s;
    m_valid = (s == 8);
  endtask

  function automatic logic [63:0] m_image();
    logic [63:0] r;
    r = m_free;
    r[3:0] = 4'(m_st);
    r[7:4] = 4'(m_last);
    r[8] = m_valid; r[9] = m_sync; r[10] = m_err;
    r[16] = m_ld; r[17] = m_mv; r[18] = m_cl; r[19] = 1'b1;
    return r;
  endfunction

  task automatic m_update(bit wr, logic [63:0] wd, bit rd, bit tu, bit tl, bit sy, bit dn);
    bit dv_now;
    dv_now = m_dv || dn;
    m_dv = dv_now;
    if (wr) begin
      m_pd = 1;
      if (wd[16] && wd[17]) begin
        m_free = wd & FREE; m_ld = 1; m_mv = 1; m_cl = wd[18]; m_sync = 0;
        m_go(9); m_err = 1; m_req = 0;
      end else if (wd[18]) begin
        m_free = wd & FREE; m_ld = 0; m_mv = 0; m_cl = 0; m_err = 0; m_sync = 0;
        m_go(0); m_req = 0; m_dv = 0;
      end else if (m_st == 9) begin
        m_err = 1; m_sync = 0;
      end else begin
        m_free = wd & FREE; m_ld = wd[16]; m_mv = wd[17]; m_cl = 0; m_sync = 0;
        if (wd[10]) m_err = 0;
        if (m_ld) m_sd = 3;
        else if (m_mv) begin
          if (m_st == 2) begin m_go(6); m_req = 1; m_sd = 3; end
          else begin m_go(9); m_err = 1; m_req = 0; end
        end
      end
    end else if (tu || tl) begin
      if (tl && m_st == 8) m_go(9);
    end else if (rd && m_st != 9) begin
      if (m_pd > 0) m_pd--; else m_sync = 1;
      if (m_sd > 0) m_sd--;
      else if (m_ld) begin
        m_ld = 0;
        if (m_st == 7) begin m_go(9); m_err = 1; end
        else begin m_go(1); m_go(2); end
      end else if (m_mv) begin
        if (m_st == 6) begin m_go(7); m_sd = 3; end
        else if (m_st == 7) begin
          if (dv_now) begin m_go(8); m_mv = 0; m_req = 0; m_dv = 0; end
        end else begin m_go(9); m_err = 1; m_req = 0; end
      end
    end
    if (sy && !wr) m_sync = 1;
  endtask

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic compare_model();
    chk(cur_req, "model rd_data", rd_data, m_image());
    chk(cur_req, "model req", 64'(req), 64'(m_req));
  endtask

  task automatic tick(bit wr, logic [63:0] wd, bit rd, bit tu, bit tl, bit sy, bit dn);
    wr_valid = wr; wr_data = wd; rd_strobe = rd; tb_up = tu; tb_lo = tl;
    sync_p = sy; done_p = dn;
    @(posedge clk);
    m_update(wr, wd, rd, tu, tl, sy, dn);
    @(negedge clk);
    wr_valid = 0; wr_data = '0; rd_strobe = 0; tb_up = 0; tb_lo = 0;
    sync_p = 0; done_p = 0;
    compare_model();
  endtask

  task automatic wr(logic [63:0] d);  tick(1, d, 0, 0, 0, 0, 0); endtask
  task automatic rd();                tick(0, '0, 1, 0, 0, 0, 0); endtask
  task automatic reads(int n);        for (int i = 0; i < n; i++) rd(); endtask

  localparam logic [63:0] C_LOAD = 64'h1_0000;
  localparam logic [63:0] C_MOVE = 64'h2_0000;
  localparam logic [63:0] C_CLR  = 64'h4_0000;

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare_model();
    chk("R1", "reset image", rd_data, 64'h0000_0000_0008_0000);
    chk("R1", "reset req", 64'(req), 64'd0);

    // Load-mode pass, sync return, free bits.
    cur_req = "R4";
    wr(C_LOAD | 64'hABCD_0000_0000_F800);
    chk("R12", "free bits", rd_data & 64'hFFFF_FFFF_FFF0_F800, 64'hABCD_0000_0000_F800);
    chk("R11", "sync cleared", 64'(rd_data[9]), 64'd0);
    rd();
    chk("R11", "sync after 1 read", 64'(rd_data[9]), 64'd0);
    rd();
    chk("R11", "sync after 2 reads", 64'(rd_data[9]), 64'd1);
    rd();
    chk("R4", "state during delay", 64'(rd_data[3:0]), 64'd0);
    rd();
    chk("R4", "state after delay", 64'(rd_data[3:0]), 64'd2);
    chk("R3", "last after load pass", 64'(rd_data[7:4]), 64'd1);
    chk("R4", "load bit cleared", 64'(rd_data[16]), 64'd0);

    // Move command sequence.
    cur_req = "R5";
    wr(C_MOVE);
    chk("R5", "sync-wait", 64'(rd_data[3:0]), 64'd6);
    chk("R3", "last is not-set", 64'(rd_data[7:4]), 64'd2);
    chk("R5", "req raised", 64'(req), 64'd1);
    cur_req = "R6";
    reads(3);
    chk("R6", "still sync-wait", 64'(rd_data[3:0]), 64'd6);
    rd();
    chk("R6", "get-time", 64'(rd_data[3:0]), 64'd7);
    reads(4);
    chk("R6", "waits for delivery", 64'(rd_data[3:0]), 64'd7);
    tick(0, '0, 1, 0, 0, 0, 1); // delivery in the same cycle as the deciding read
    chk("R6", "running", 64'(rd_data[3:0]), 64'd8);
    chk("R2", "valid in running", 64'(rd_data[8]), 64'd1);
    chk("R6", "move cleared", 64'(rd_data[17]), 64'd0);
    chk("R6", "req dropped", 64'(req), 64'd0);

    // Timebase half writes while running.
    cur_req = "R10";
    tick(0, '0, 0, 1, 0, 0, 0);
    chk("R10", "upper keeps running", 64'(rd_data[3:0]), 64'd8);
    tick(0, '0, 0, 0, 1, 0, 0);
    chk("R10", "lower -> error", 64'(rd_data[3:0]), 64'd9);
    chk("R2", "valid off", 64'(rd_data[8]), 64'd0);

    // Writes and reads in error.
    cur_req = "R9";
    wr(C_LOAD);
    chk("R9", "state held", 64'(rd_data[3:0]), 64'd9);
    chk("R9", "error flag", 64'(rd_data[10]), 64'd1);
    chk("R9", "load not taken", 64'(rd_data[16]), 64'd0);
    reads(2);
    chk("R9", "reads do not step", 64'(rd_data[9:0]), 64'h089);

    cur_req = "R8";
    wr(C_CLR);
    chk("R8", "reset state", 64'(rd_data[3:0]), 64'd0);
    chk("R8", "last error", 64'(rd_data[7:4]), 64'd9);
    chk("R8", "flags cleared", 64'(rd_data[18:16]) | 64'(rd_data[10]), 64'd0);

    cur_req = "R5";
    wr(C_MOVE);
    chk("R5", "move from reset -> error", 64'(rd_data[3:0]), 64'd9);
    chk("R5", "error flag", 64'(rd_data[10]), 64'd1);
    chk("R5", "req low", 64'(req), 64'd0);
    wr(C_CLR);

    // Not-set: timebase writes and the command conflict.
    cur_req = "R10";
    wr(C_LOAD); reads(4);
    tick(0, '0, 0, 0, 1, 0, 0);
    tick(0, '0, 0, 1, 0, 0, 0);
    chk("R10", "not-set unchanged", 64'(rd_data[3:0]), 64'd2);
    cur_req = "R7";
    wr(C_LOAD | C_MOVE);
    chk("R7", "conflict -> error", 64'(rd_data[3:0]), 64'd9);
    chk("R7", "error flag", 64'(rd_data[10]), 64'd1);
    wr(C_CLR);

    // Load-mode processed in get-time.
    cur_req = "R4";
    wr(C_LOAD); reads(4);
    wr(C_MOVE); reads(4);
    chk("R4", "reached get-time", 64'(rd_data[3:0]), 64'd7);
    wr(C_LOAD); reads(4);
    chk("R4", "load in get-time -> error", 64'(rd_data[3:0]), 64'd9);
    chk("R4", "error flag", 64'(rd_data[10]), 64'd1);
    wr(C_CLR);

    // Sync pulse input and collision with a write.
    cur_req = "R11";
    wr('0);
    tick(0, '0, 0, 0, 0, 1, 0);
    chk("R11", "pulse sets sync", 64'(rd_data[9]), 64'd1);
    tick(1, '0, 0, 0, 0, 1, 0);
    chk("R11", "write wins over pulse", 64'(rd_data[9]), 64'd0);

    cur_req = "R12";
    wr(64'h0);
    chk("R12", "mode reads one", 64'(rd_data[19]), 64'd1);

    summary();
  end

endmodule